// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Critical-Word-First Refill

This block is a level-1 data cache, direct mapped, that sits between a processor's load path and a slower backing memory. It holds a fixed number of lines, each a run of contiguous words that starts on a line-sized boundary. The processor presents a byte address and holds its request until it sees a one-cycle ready pulse with the word. A hit answers one cycle after the request, without touching the backing memory.

On a miss the cache asks the backing memory for the whole line, starting with the word the processor wants. The memory returns one word per beat with a valid strobe. The first beat is the requested (critical) word, and the following beats wrap around the line. The critical word goes straight to the processor in the cycle its beat arrives, so the processor restarts early. The remaining beats fill the line in the background. The line is marked valid, with its new tag, only once the last beat has been written. While a refill is running, the cache can still answer hits to other lines. A request to the line being refilled waits for the refill to finish. A miss to any line waits until the refill engine is free.

The block has two state machines. The request port FSM has three states. `PORT_IDLE` goes to `PORT_HIT` on a hit to a line that is not being refilled. It goes to `PORT_MISS` on a miss when the refill engine is idle, and that transition starts a refill. `PORT_HIT` returns to `PORT_IDLE` after one cycle. `PORT_MISS` returns to `PORT_IDLE` in the cycle the critical word is forwarded. The refill FSM has four states. `FILL_IDLE` goes to `FILL_ISSUE` on a start. `FILL_ISSUE` issues the one-cycle memory request and goes to `FILL_CRIT`. `FILL_CRIT` takes the first beat and goes to `FILL_REST`. `FILL_REST` takes the remaining beats and returns to `FILL_IDLE` after the last one, at which point it writes the tag and sets the valid bit.

Top module: `cwf_cache`

## Requirements
- R1: The byte address splits into byte offset bits [1:0] (ignored for reads), word-in-line bits [4:2], then log2(LINES) line-index bits, with the tag in all remaining upper bits. Requests that differ only in bits [1:0] return the same word.
- R2: Reset clears every valid bit, so after reset `rsp_ready` and `mem_req` are low and the first access to any line is a miss that issues a memory request.
- R3: On a hit to a line not under refill, `rsp_ready` is high in the cycle after the request is presented, with the stored word on `rsp_data`, and `mem_req` stays low.
- R4: A miss raises `mem_req` for exactly one cycle, with `mem_addr` equal to the requested address with bits [1:0] cleared. Only one memory request is made per missed line.
- R5: The memory returns 8 beats. Beat k carries word (c + k) mod 8 of the line, where c is the critical word index. The cache stores each beat at that word position, so later hits to every word of the line return the memory's data.
- R6: The requested word is forwarded on `rsp_data` with `rsp_ready` high in the same cycle that the first beat has `mem_rvalid` high.
- R7: The valid bit and tag of a line change only after its 8th beat is written. A request to the line index under refill gets no response until the refill has completed.
- R8: A hit to a different line is answered with one-cycle latency while a refill continues in the background.
- R9: A miss that arrives while a refill is in progress issues no memory request until that refill has taken its last beat.
- R10: A miss replaces the line at its index. The previously held address at that index then misses and is refetched.
- R11: `rsp_ready` is a single-cycle pulse for each request and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor read request, held until `rsp_ready` |
| req_addr | input | ADDR_W | Byte address of the requested word |
| rsp_ready | output | 1 | One-cycle pulse: `rsp_data` holds the requested word |
| rsp_data | output | WORD_W | Returned word |
| mem_req | output | 1 | One-cycle line refill request |
| mem_addr | output | ADDR_W | Word-aligned address of the critical word |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | WORD_W | Refill beat data |

## Verification
The bench builds the cache with a 16-bit address and 16 lines, and keeps the default 32-bit words and 8-word lines. With only 7 tag bits and 16 indices, random addresses drawn from four tags collide often. This makes replacements, hits to a line under refill, and misses queued behind an active refill frequent. The bench's memory model adds random gaps between beats, so refills overlap the next request. Directed reads start refills at word 0, in the middle of the line, and at the last word, which checks the wrap-around placement.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_HIT,
        PORT_MISS
    } port_state_e;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_ISSUE,
        FILL_CRIT,
        FILL_REST
    } fill_state_e;

endpackage

// File: rtl/cwf_tag_store.sv
module cwf_tag_store #(
    parameter int LINES = 1024,
    parameter int TAG_W = 17,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits are reset; tags need no reset because valid guards them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
    parameter int LINES  = 1024,
    parameter int WPL    = 8,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WIDX_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data
);

    // One entry per line; each entry is a packed row of words, written one
    // word per refill beat.
    logic [WPL-1:0][WORD_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx][wr_word] <= wr_data;
        end
    end

    assign rd_data = line_q[rd_idx][rd_word];

endmodule

// File: rtl/cwf_fill_engine.sv
module cwf_fill_engine
    import cwf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WPL    = 8,
    parameter int LINES  = 1024,
    localparam int OFF_W  = $clog2(WORD_W / 8),
    localparam int WIDX_W = $clog2(WPL),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - OFF_W - WIDX_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              crit_fwd,
    output logic              done,
    output logic              wr_en,
    output logic [WIDX_W-1:0] wr_word,
    output logic [WORD_W-1:0] wr_data
);

    fill_state_e state_q, state_d;
    logic [ADDR_W-1:OFF_W] addr_q;
    logic [WIDX_W-1:0]     beat_q;
    logic [WIDX_W-1:0]     crit_word;
    logic                  last_beat;

    assign crit_word = addr_q[OFF_W +: WIDX_W];
    assign fill_idx  = addr_q[OFF_W + WIDX_W +: IDX_W];
    assign fill_tag  = addr_q[ADDR_W-1 -: TAG_W];
    assign last_beat = (beat_q == WIDX_W'(WPL - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE:  if (start) state_d = FILL_ISSUE;
            FILL_ISSUE: state_d = FILL_CRIT;
            FILL_CRIT:  if (mem_rvalid) state_d = FILL_REST;
            FILL_REST:  if (mem_rvalid && last_beat) state_d = FILL_IDLE;
            default:    state_d = FILL_IDLE;
        endcase
    end

    // Address capture and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            beat_q <= '0;
        end else begin
            if (state_q == FILL_IDLE && start) begin
                addr_q <= start_addr[ADDR_W-1:OFF_W];
                beat_q <= '0;
            end else if ((state_q == FILL_CRIT || state_q == FILL_REST) && mem_rvalid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req  = (state_q == FILL_ISSUE);
        mem_addr = {addr_q, {OFF_W{1'b0}}};
        busy     = (state_q != FILL_IDLE);
        wr_en    = (state_q == FILL_CRIT || state_q == FILL_REST) && mem_rvalid;
        crit_fwd = (state_q == FILL_CRIT) && mem_rvalid;
        done     = (state_q == FILL_REST) && mem_rvalid && last_beat;
        wr_word  = crit_word + beat_q;
        wr_data  = mem_rdata;
    end

    AST_ONE_REQ_PER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R4

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9

endmodule

// File: rtl/cwf_cache.sv
module cwf_cache
    import cwf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WPL    = 8,
    parameter int LINES  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);

    localparam int OFF_W  = $clog2(WORD_W / 8);
    localparam int WIDX_W = $clog2(WPL);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - WIDX_W - IDX_W;

    port_state_e state_q, state_d;

    logic [WIDX_W-1:0] req_word;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              unused_byte_bits;

    logic              look_valid;
    logic [TAG_W-1:0]  look_tag;
    logic              look_hit;
    logic [WORD_W-1:0] look_data;
    logic              blocked;
    logic              fill_start;

    logic              fill_busy;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic              crit_fwd;
    logic              fill_done;
    logic              line_wr_en;
    logic [WIDX_W-1:0] line_wr_word;
    logic [WORD_W-1:0] line_wr_data;

    logic [WORD_W-1:0] hit_data_q;
    logic [IDX_W-1:0]  hit_idx_q;

    assign req_word         = req_addr[OFF_W +: WIDX_W];
    assign req_idx          = req_addr[OFF_W + WIDX_W +: IDX_W];
    assign req_tag          = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_byte_bits = ^req_addr[OFF_W-1:0];

    cwf_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (look_valid),
        .rd_tag   (look_tag),
        .wr_en    (fill_done),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_tag)
    );

    cwf_line_store #(
        .LINES  (LINES),
        .WPL    (WPL),
        .WORD_W (WORD_W)
    ) u_lines (
        .clk     (clk),
        .wr_en   (line_wr_en),
        .wr_idx  (fill_idx),
        .wr_word (line_wr_word),
        .wr_data (line_wr_data),
        .rd_idx  (req_idx),
        .rd_word (req_word),
        .rd_data (look_data)
    );

    cwf_fill_engine #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .WPL    (WPL),
        .LINES  (LINES)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fill_start),
        .start_addr (req_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (fill_busy),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .crit_fwd   (crit_fwd),
        .done       (fill_done),
        .wr_en      (line_wr_en),
        .wr_word    (line_wr_word),
        .wr_data    (line_wr_data)
    );

    assign look_hit = look_valid && (look_tag == req_tag);
    assign blocked  = fill_busy && (fill_idx == req_idx);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: begin
                if (req_valid && !blocked) begin
                    if (look_hit)        state_d = PORT_HIT;
                    else if (!fill_busy) state_d = PORT_MISS;
                end
            end
            PORT_HIT:  state_d = PORT_IDLE;
            PORT_MISS: if (crit_fwd) state_d = PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // Hit data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_data_q <= '0;
            hit_idx_q  <= '0;
        end else if (state_q == PORT_IDLE && state_d == PORT_HIT) begin
            hit_data_q <= look_data;
            hit_idx_q  <= req_idx;
        end
    end

    // Outputs
    always_comb begin
        fill_start = (state_q == PORT_IDLE) && (state_d == PORT_MISS);
        rsp_ready  = (state_q == PORT_HIT) || ((state_q == PORT_MISS) && crit_fwd);
        rsp_data   = (state_q == PORT_MISS) ? mem_rdata : hit_data_q;
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R11

    AST_HIT_NO_MEM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_HIT) |-> !mem_req); // R3

    AST_HIT_NOT_FILL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_HIT && fill_busy) |-> (hit_idx_q != fill_idx)); // R7

    AST_MEM_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W]))); // R4

    AST_FWD_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        crit_fwd |-> (state_q == PORT_MISS)); // R6

endmodule

// File: tb/cwf_cache_bench.sv
module cwf_cache_bench;

    localparam int AW  = 16;
    localparam int WW  = 32;
    localparam int WPL = 8;
    localparam int NL  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          rsp_ready;
    logic [WW-1:0] rsp_data;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [WW-1:0] mem_rdata;

    always #10 clk = ~clk;

    cwf_cache #(
        .ADDR_W (AW),
        .WORD_W (WW),
        .WPL    (WPL),
        .LINES  (NL)
    ) u_cwf_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .rsp_ready  (rsp_ready),
        .rsp_data   (rsp_data),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    int        n_checks = 0;
    int        n_fails  = 0;
    bit        fill_active = 1'b0;
    logic [3:0] fill_idx_tb = '0;
    bit        mv [NL];
    logic [6:0] mt [NL];
    bit        done_flag = 1'b0;

    function automatic logic [WW-1:0] word_of(input logic [AW-1:0] a);
        logic [13:0] w;
        w = a[15:2];
        return {2'b10, w, 2'b01, w ^ 14'h1555};
    endfunction

    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int wd, input int by);
        return {7'(tag), 4'(idx), 3'(wd), 2'(by)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #2;
    endtask

    task automatic report;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // Backing memory: wrap-around beats with random gaps (R5)
    initial begin
        logic [AW-1:0] base;
        logic [2:0]    crit;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            #1;
            if (mem_req) begin
                fill_active = 1'b1;
                base        = mem_addr;
                crit        = mem_addr[4:2];
                fill_idx_tb = mem_addr[8:5];
                for (int k = 0; k < WPL; k++) begin
                    int gaps;
                    gaps = (k == 0) ? 1 + int'($urandom % 3) : int'($urandom % 3);
                    repeat (gaps) begin
                        @(negedge clk);
                        #1;
                        mem_rvalid = 1'b0;
                        if (mem_req) check(1'b0, "R9 request during refill", 32'(mem_req), 32'd0);
                    end
                    @(negedge clk);
                    #1;
                    if (mem_req) check(1'b0, "R4 second request during refill", 32'(mem_req), 32'd0);
                    mem_rvalid = 1'b1;
                    mem_rdata  = word_of({base[15:5], 3'(crit + 3'(k)), 2'b00});
                end
                @(negedge clk);
                #1;
                mem_rvalid  = 1'b0;
                fill_active = 1'b0;
            end
        end
    end

    task automatic do_read(input logic [AW-1:0] addr, input string tagname);
        bit  exp_hit, started_fill, same_line, got;
        int  lat, nreq;
        logic [3:0] idx;
        logic [6:0] tg;
        idx = addr[8:5];
        tg  = addr[15:9];
        tick;
        check(rsp_ready == 1'b0, "R11 ready low between requests", 32'(rsp_ready), 32'd0);
        exp_hit      = mv[idx] && (mt[idx] == tg);
        started_fill = fill_active;
        same_line    = started_fill && (fill_idx_tb == idx);
        req_valid = 1'b1;
        req_addr  = addr;
        got  = 1'b0;
        lat  = 0;
        nreq = 0;
        while (!got && lat < 60) begin
            tick;
            lat++;
            if (mem_req) begin
                nreq++;
                check(mem_addr == {addr[15:2], 2'b00}, "R4 memory address", 32'(mem_addr), 32'({addr[15:2], 2'b00}));
            end
            if (rsp_ready) got = 1'b1;
        end
        req_valid = 1'b0;
        check(got, {"R3/R6 response arrives ", tagname}, 32'(got), 32'd1);
        if (got) begin
            check(rsp_data == word_of(addr), {"R5 returned word ", tagname}, rsp_data, word_of(addr));
            if (exp_hit) begin
                check(nreq == 0, {"R3 no memory access on hit ", tagname}, 32'(nreq), 32'd0);
                if (same_line)
                    check(!fill_active, {"R7 held until refill done ", tagname}, 32'(fill_active), 32'd0);
                else
                    check(lat == 1, {"R3/R8 hit latency ", tagname}, 32'(lat), 32'd1);
            end else begin
                check(nreq == 1, {"R2/R4/R10 one request per miss ", tagname}, 32'(nreq), 32'd1);
                check(mem_rvalid == 1'b1, {"R6 early restart on first beat ", tagname}, 32'(mem_rvalid), 32'd1);
                mv[idx] = 1'b1;
                mt[idx] = tg;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        req_valid = 1'b0;
        req_addr  = '0;
        for (int i = 0; i < NL; i++) begin
            mv[i] = 1'b0;
            mt[i] = '0;
        end
        repeat (4) @(negedge clk);
        #2;
        check(rsp_ready == 1'b0, "R2 ready low in reset", 32'(rsp_ready), 32'd0);
        check(mem_req == 1'b0, "R2 mem_req low in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;

        // R2: first access misses; R1: byte offset ignored
        do_read(mk(1, 2, 5, 0), "R2 first access");
        do_read(mk(1, 2, 5, 3), "R1 byte offset");
        // R5: every word of a line refilled from the middle
        for (int w = 0; w < WPL; w++) do_read(mk(1, 2, w, w % 4), "R5 mid wrap");
        // R5: refill starting at the last word
        do_read(mk(0, 9, 7, 0), "R5 last word crit");
        for (int w = 0; w < WPL; w++) do_read(mk(0, 9, w, 0), "R5 end wrap");
        // R7: same line right after early restart
        do_read(mk(1, 3, 6, 0), "R7 miss");
        do_read(mk(1, 3, 1, 0), "R7 same line");
        // R8: hit elsewhere during refill
        do_read(mk(2, 4, 0, 0), "R8 miss");
        do_read(mk(1, 2, 3, 0), "R8 hit under refill");
        // R9: miss queued behind refill
        do_read(mk(3, 5, 7, 0), "R9 first miss");
        do_read(mk(3, 6, 2, 0), "R9 queued miss");
        // R10: conflict replacement
        do_read(mk(5, 2, 5, 0), "R10 evict");
        do_read(mk(1, 2, 5, 0), "R10 refetch");

        for (int n = 0; n < 400; n++) begin
            repeat ($urandom % 3) tick;
            do_read(mk(int'($urandom % 4), int'($urandom % NL), int'($urandom % WPL), int'($urandom % 4)), "random");
        end
        wait (!fill_active);
        repeat (3) tick;
        report();
    end

endmodule